// File: doc/BRIEF.md
# Windowed Best-Path Interval Segmenter

The engine turns a stream of scene segments into the most likely chain of non-overlapping intervals. Each interval is labelled with one of three motion modes. Each time a segment closes, the host presents its duration on `seg_dur` with a one-cycle `seg_valid` pulse. The engine then revisits every boundary it still holds, from oldest to newest. It adds the new duration to each boundary's running total and drops, for good, any boundary whose interval would now be longer than `TMAX`. For each boundary that survives, it sends that boundary's stored per-mode partial likelihoods to an external scorer. The scorer returns the partials extended by the new segment, together with the best mode and its likelihood. The engine multiplies that likelihood by the boundary's path cost and keeps the largest product. One last request, marked fresh, scores the interval made of the newest segment alone.

When the pass ends, the engine stores the boundary in front of the newest segment in the node store. It holds that segment's duration, its fresh partials and its path cost. The engine also appends an edge record, holding the winning mode and a link to the edge that ended at the winning source. When the host sees a segment outlast `TMAX`, it pulses `flush`. The engine then walks the edge links backward and presents one mode per cycle, newest first, followed by a done pulse. After that it is back in its start state. All likelihoods and costs are 16-bit unsigned fractions. A product keeps the upper 16 bits of the 32-bit result.

The controller has six states:
- IDLE waits. It goes to WALK on `seg_valid` and to TRACE on `flush`.
- WALK looks at the next stored boundary. It stays in WALK after dropping an expired boundary, goes to EXTEND for a surviving boundary, and goes to FRESH when none are left.
- EXTEND holds its request until the response arrives, then goes back to WALK.
- FRESH holds the fresh request until the response arrives, then goes to COMMIT.
- COMMIT writes the node and the edge, then goes to IDLE.
- TRACE emits one mode per cycle and goes to IDLE after its done cycle.

Top module: `ml_path_engine`

## Requirements
- R1: After reset `busy`, `sc_req`, `trace_valid`, `trace_done` and `overflow` are all 0. While `busy` is 0, `sc_req` and `trace_valid` stay 0.
- R2: A `seg_valid` pulse seen in IDLE starts exactly one insertion. `sc_req` then stays high, with a stable payload, until `sc_rsp_valid`. Each insertion ends with exactly one request that has `sc_fresh`=1.
- R3: A stored boundary is scored only while its total duration, including the new segment, is at most `TMAX` (a total equal to `TMAX` is kept). Once the total exceeds `TMAX`, the boundary is never requested again. The number of requests with `sc_fresh`=0 in an insertion therefore equals the number of earlier boundaries still inside the window.
- R4: A candidate cost is the upper 16 bits of the scorer's best likelihood times the source path cost. Sources are taken oldest first, with the fresh interval last. A later candidate replaces the held one only if it is strictly larger.
- R5: The start boundary has path cost 16'hFFFF and duration 0.
- R6: For each surviving boundary, the request payload equals the partials returned for that boundary in the previous insertion, or its fresh partials. The payload packs mode k in bits [16k+15:16k].
- R7: A `flush` pulse in IDLE emits the mode chain of the best path: one `trace_valid` cycle per interval, newest first, with the scorer's 2-bit mode code on `trace_mode`. A single `trace_done` cycle follows the last mode. With no intervals recorded, only `trace_done` appears.
- R8: After `trace_done` the engine returns to its start state. The boundary store and the edge store are emptied, the path cost returns to 16'hFFFF and `overflow` clears.
- R9: With both stores 16 deep, the 17th insertion in a session sets `overflow`. The flag stays set until the next `trace_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_valid | input | 1 | A segment has closed; accepted only in IDLE |
| seg_dur | input | 8 | Duration of the closed segment, at most TMAX |
| flush | input | 1 | Start the backward trace (IDLE only) |
| busy | output | 1 | Engine is not in IDLE |
| sc_req | output | 1 | Scoring request, held until the response |
| sc_fresh | output | 1 | Request scores the newest segment alone |
| sc_part | output | 48 | Stored partials of the boundary being extended |
| sc_rsp_valid | input | 1 | Scorer response strobe |
| sc_rsp_part | input | 48 | Extended or fresh partials from the scorer |
| sc_rsp_best | input | 16 | Best mode likelihood |
| sc_rsp_mode | input | 2 | Best mode code |
| trace_valid | output | 1 | `trace_mode` holds one interval's mode |
| trace_mode | output | 2 | Mode code during the trace |
| trace_done | output | 1 | One-cycle end-of-trace pulse |
| overflow | output | 1 | A store push was refused in this session |

## Verification
The bench builds each expected path with a separate dynamic program over the segment list. That program uses the same fractional rounding and the oldest-first, strict-greater rule. If the design kept the later of two equal candidates, or evaluated the fresh interval before the stored ones, the bench would see a different mode chain. Directed window cases put a running total exactly at `TMAX` and one step above it. A design that compared with the wrong inequality would issue one request too many or too few. Equal likelihoods across modes and sources exercise the tie rule. A run of 17 one-unit segments shows whether `overflow` rises on the 17th insertion rather than the 16th. It also shows whether the following trace leaves a clean session behind, since a stale store would corrupt the next checked chain.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
    localparam int PROB_W = 16;
    localparam int NMODE  = 3;
    localparam int MODE_W = 2;
    localparam int PART_W = PROB_W * NMODE;

    typedef logic [PROB_W-1:0] prob_t;
    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [PART_W-1:0] part_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK,
        ST_EXTEND,
        ST_FRESH,
        ST_COMMIT,
        ST_TRACE
    } eng_state_t;

    function automatic prob_t frac_mul(input prob_t a, input prob_t b);
        logic [2*PROB_W-1:0] full;
        full = a * b;
        return full[2*PROB_W-1:PROB_W];
    endfunction
endpackage

// File: rtl/mlp_node_store.sv
module mlp_node_store
    import mlp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int ACC_W = 8,
    parameter int EP_W  = 5,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [AW-1:0]   rd_idx,
    output logic [ACC_W-1:0] rd_acc,
    output part_t           rd_part,
    output prob_t           rd_cost,
    output logic [EP_W-1:0] rd_ep,
    input  logic            upd_en,
    input  logic [ACC_W-1:0] upd_acc,
    input  part_t           upd_part,
    input  logic            pop,
    input  logic            push,
    input  logic [ACC_W-1:0] push_acc,
    input  part_t           push_part,
    input  prob_t           push_cost,
    input  logic [EP_W-1:0] push_ep,
    output logic [AW-1:0]   head,
    output logic [AW:0]     count,
    output logic            full
);
    logic [ACC_W-1:0] acc_mem  [DEPTH];
    part_t            part_mem [DEPTH];
    prob_t            cost_mem [DEPTH];
    logic [EP_W-1:0]  ep_mem   [DEPTH];
    logic [AW-1:0]    tail;

    assign tail    = head + count[AW-1:0];
    assign full    = (count == (AW+1)'(DEPTH));
    assign rd_acc  = acc_mem[rd_idx];
    assign rd_part = part_mem[rd_idx];
    assign rd_cost = cost_mem[rd_idx];
    assign rd_ep   = ep_mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else if (clear) begin
            head  <= '0;
            count <= '0;
        end else if (pop) begin
            head  <= head + 1'b1;
            count <= count - 1'b1;
        end else if (push && !full) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en) begin
            acc_mem[rd_idx]  <= upd_acc;
            part_mem[rd_idx] <= upd_part;
        end else if (push && !full) begin
            acc_mem[tail]  <= push_acc;
            part_mem[tail] <= push_part;
            cost_mem[tail] <= push_cost;
            ep_mem[tail]   <= push_ep;
        end
    end
endmodule

// File: rtl/mlp_edge_store.sv
module mlp_edge_store
    import mlp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int EP_W  = 5,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            wr_en,
    input  mode_t           wr_mode,
    input  logic [EP_W-1:0] wr_prev,
    output logic [AW-1:0]   wr_idx,
    output logic            full,
    input  logic [AW-1:0]   rd_idx,
    output mode_t           rd_mode,
    output logic [EP_W-1:0] rd_prev
);
    mode_t           mode_mem [DEPTH];
    logic [EP_W-1:0] prev_mem [DEPTH];
    logic [AW:0]     fill;

    assign wr_idx  = fill[AW-1:0];
    assign full    = (fill == (AW+1)'(DEPTH));
    assign rd_mode = mode_mem[rd_idx];
    assign rd_prev = prev_mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                fill <= '0;
        else if (clear)            fill <= '0;
        else if (wr_en && !full)   fill <= fill + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            mode_mem[wr_idx] <= wr_mode;
            prev_mem[wr_idx] <= wr_prev;
        end
    end
endmodule

// File: rtl/ml_path_engine.sv
module ml_path_engine
    import mlp_pkg::*;
#(
    parameter int NODE_DEPTH = 16,
    parameter int EDGE_DEPTH = 16,
    parameter int DUR_W      = 8,
    parameter int TMAX       = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seg_valid,
    input  logic [DUR_W-1:0]    seg_dur,
    input  logic                flush,
    output logic                busy,
    output logic                sc_req,
    output logic                sc_fresh,
    output logic [PART_W-1:0]   sc_part,
    input  logic                sc_rsp_valid,
    input  logic [PART_W-1:0]   sc_rsp_part,
    input  logic [PROB_W-1:0]   sc_rsp_best,
    input  logic [MODE_W-1:0]   sc_rsp_mode,
    output logic                trace_valid,
    output logic [MODE_W-1:0]   trace_mode,
    output logic                trace_done,
    output logic                overflow
);
    localparam int NAW  = $clog2(NODE_DEPTH);
    localparam int EAW  = $clog2(EDGE_DEPTH);
    localparam int EP_W = EAW + 1;
    localparam int SUM_W = DUR_W + 1;
    localparam prob_t START_COST = '1;

    eng_state_t state, state_nx;

    logic [DUR_W-1:0] dur_q;
    logic [NAW-1:0]   idx_q;
    logic [NAW:0]     left_q;
    prob_t            best_cost;
    mode_t            best_mode;
    logic [EP_W-1:0]  best_src;
    logic             have_best;
    part_t            fresh_part;
    prob_t            prev_cost;
    logic [EP_W-1:0]  prev_ep;
    logic [EP_W-1:0]  trace_ep;
    logic             ovf_q;

    logic [DUR_W-1:0] rd_acc;
    part_t            rd_part;
    prob_t            rd_cost;
    logic [EP_W-1:0]  rd_ep;
    logic [NAW-1:0]   node_head;
    logic [NAW:0]     node_count;
    logic             node_full;
    logic [EAW-1:0]   edge_wr_idx;
    logic             edge_full;
    mode_t            edge_rd_mode;
    logic [EP_W-1:0]  edge_rd_prev;

    logic [SUM_W-1:0] win_sum;
    logic             expired;
    prob_t            cand;
    logic             better;
    logic             node_pop, node_upd, node_push, edge_wr, session_clear;

    assign win_sum  = {1'b0, rd_acc} + {1'b0, dur_q};
    assign expired  = win_sum > SUM_W'(TMAX);
    assign cand     = frac_mul(sc_rsp_best, (state == ST_FRESH) ? prev_cost : rd_cost);
    assign better   = !have_best || (cand > best_cost);

    assign node_pop      = (state == ST_WALK) && (left_q != '0) && expired;
    assign node_upd      = (state == ST_EXTEND) && sc_rsp_valid;
    assign node_push     = (state == ST_COMMIT);
    assign edge_wr       = (state == ST_COMMIT);
    assign session_clear = (state == ST_TRACE) && !trace_ep[EP_W-1];

    mlp_node_store #(.DEPTH(NODE_DEPTH), .ACC_W(DUR_W), .EP_W(EP_W)) u_nodes (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (session_clear),
        .rd_idx    (idx_q),
        .rd_acc    (rd_acc),
        .rd_part   (rd_part),
        .rd_cost   (rd_cost),
        .rd_ep     (rd_ep),
        .upd_en    (node_upd),
        .upd_acc   (win_sum[DUR_W-1:0]),
        .upd_part  (sc_rsp_part),
        .pop       (node_pop),
        .push      (node_push),
        .push_acc  (dur_q),
        .push_part (fresh_part),
        .push_cost (prev_cost),
        .push_ep   (prev_ep),
        .head      (node_head),
        .count     (node_count),
        .full      (node_full)
    );

    mlp_edge_store #(.DEPTH(EDGE_DEPTH), .EP_W(EP_W)) u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (session_clear),
        .wr_en   (edge_wr),
        .wr_mode (best_mode),
        .wr_prev (best_src),
        .wr_idx  (edge_wr_idx),
        .full    (edge_full),
        .rd_idx  (trace_ep[EAW-1:0]),
        .rd_mode (edge_rd_mode),
        .rd_prev (edge_rd_prev)
    );

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (seg_valid) state_nx = ST_WALK;
                       else if (flush) state_nx = ST_TRACE;
            ST_WALK:   if (left_q == '0) state_nx = ST_FRESH;
                       else if (!expired) state_nx = ST_EXTEND;
            ST_EXTEND: if (sc_rsp_valid) state_nx = ST_WALK;
            ST_FRESH:  if (sc_rsp_valid) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            ST_TRACE:  if (!trace_ep[EP_W-1]) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dur_q      <= '0;
            idx_q      <= '0;
            left_q     <= '0;
            best_cost  <= '0;
            best_mode  <= '0;
            best_src   <= '0;
            have_best  <= 1'b0;
            fresh_part <= '0;
            prev_cost  <= START_COST;
            prev_ep    <= '0;
            trace_ep   <= '0;
            ovf_q      <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (seg_valid) begin
                        dur_q     <= seg_dur;
                        idx_q     <= node_head;
                        left_q    <= node_count;
                        have_best <= 1'b0;
                        best_cost <= '0;
                    end else if (flush) begin
                        trace_ep  <= prev_ep;
                    end
                end
                ST_WALK: begin
                    if (node_pop) begin
                        idx_q  <= idx_q + 1'b1;
                        left_q <= left_q - 1'b1;
                    end
                end
                ST_EXTEND: begin
                    if (sc_rsp_valid) begin
                        if (better) begin
                            best_cost <= cand;
                            best_mode <= sc_rsp_mode;
                            best_src  <= rd_ep;
                            have_best <= 1'b1;
                        end
                        idx_q  <= idx_q + 1'b1;
                        left_q <= left_q - 1'b1;
                    end
                end
                ST_FRESH: begin
                    if (sc_rsp_valid) begin
                        if (better) begin
                            best_cost <= cand;
                            best_mode <= sc_rsp_mode;
                            best_src  <= prev_ep;
                            have_best <= 1'b1;
                        end
                        fresh_part <= sc_rsp_part;
                    end
                end
                ST_COMMIT: begin
                    prev_cost <= best_cost;
                    if (!edge_full) prev_ep <= {1'b1, edge_wr_idx};
                    if (node_full || edge_full) ovf_q <= 1'b1;
                end
                ST_TRACE: begin
                    if (trace_ep[EP_W-1]) begin
                        trace_ep <= edge_rd_prev;
                    end else begin
                        prev_cost <= START_COST;
                        prev_ep   <= '0;
                        ovf_q     <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        sc_req      = (state == ST_EXTEND) || (state == ST_FRESH);
        sc_fresh    = (state == ST_FRESH);
        sc_part     = (state == ST_EXTEND) ? rd_part : '0;
        trace_valid = (state == ST_TRACE) && trace_ep[EP_W-1];
        trace_mode  = trace_valid ? edge_rd_mode : '0;
        trace_done  = session_clear;
        overflow    = ovf_q;
    end
endmodule

// File: rtl/mlp_checker.sv
module mlp_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sc_req,
    input logic sc_fresh,
    input logic sc_rsp_valid,
    input logic trace_valid,
    input logic trace_done,
    input logic overflow
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req && !sc_rsp_valid |=> sc_req);                       // R2
    AST_REQ_KIND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req && !sc_rsp_valid |=> $stable(sc_fresh));            // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sc_req && !trace_valid);                        // R1
    AST_TRACE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(trace_valid && trace_done));                             // R7
    AST_DONE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        trace_done |=> !overflow && !busy);                        // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !trace_done |=> overflow);                     // R9
endmodule

bind ml_path_engine mlp_checker u_chk (.*);

// File: tb/ml_path_engine_tb.sv
module ml_path_engine_tb;
    localparam int TMAX = 100;
    localparam int MAXS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_valid = 1'b0;
    logic [7:0]  seg_dur = '0;
    logic        flush = 1'b0;
    logic        busy, sc_req, sc_fresh;
    logic [47:0] sc_part;
    logic        sc_rsp_valid = 1'b0;
    logic [47:0] sc_rsp_part = '0;
    logic [15:0] sc_rsp_best = '0;
    logic [1:0]  sc_rsp_mode = '0;
    logic        trace_valid, trace_done, overflow;
    logic [1:0]  trace_mode;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ml_path_engine u_dut (
        .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_dur(seg_dur),
        .flush(flush), .busy(busy), .sc_req(sc_req), .sc_fresh(sc_fresh),
        .sc_part(sc_part), .sc_rsp_valid(sc_rsp_valid), .sc_rsp_part(sc_rsp_part),
        .sc_rsp_best(sc_rsp_best), .sc_rsp_mode(sc_rsp_mode),
        .trace_valid(trace_valid), .trace_mode(trace_mode),
        .trace_done(trace_done), .overflow(overflow)
    );

    logic [15:0] P [MAXS][3];
    int          D [MAXS];
    logic [15:0] cur_p [3];
    int          ext_cnt, fresh_cnt;
    logic [31:0] rng = 32'h1234_5678;

    logic [15:0] bestc [MAXS+1];
    int          from_b [MAXS+1];
    logic [1:0]  mode_b [MAXS+1];

    function automatic logic [15:0] fm(input logic [15:0] a, input logic [15:0] b);
        logic [31:0] t;
        t = a * b;
        return t[31:16];
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scorer model: extends or starts partials with the current segment's values
    initial begin
        int lat;
        lat = 0;
        forever begin
            @(negedge clk);
            if (sc_rsp_valid) begin
                sc_rsp_valid = 1'b0;
            end else if (sc_req) begin
                if (lat == 0) begin
                    logic [15:0] pk [3];
                    logic [15:0] bv;
                    logic [1:0]  bm;
                    for (int k = 0; k < 3; k++)
                        pk[k] = sc_fresh ? cur_p[k] : fm(sc_part[16*k +: 16], cur_p[k]);
                    bv = pk[0]; bm = 2'd0;
                    for (int k = 1; k < 3; k++) if (pk[k] > bv) begin bv = pk[k]; bm = 2'(k); end
                    sc_rsp_part  = {pk[2], pk[1], pk[0]};
                    sc_rsp_best  = bv;
                    sc_rsp_mode  = bm;
                    sc_rsp_valid = 1'b1;
                    if (sc_fresh) fresh_cnt++; else ext_cnt++;
                    rng = nxt(rng);
                    lat = int'(rng[1:0]) % 3;
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic expected_path(input int n);
        bestc[0] = 16'hFFFF;
        for (int j = 1; j <= n; j++) begin
            bit have;
            logic [15:0] bc;
            have = 1'b0; bc = '0;
            for (int i = 0; i < j; i++) begin
                int sum;
                logic [15:0] pt [3];
                logic [15:0] bv, c;
                logic [1:0]  bm;
                sum = 0;
                for (int q = i; q < j; q++) sum += D[q];
                if (sum <= TMAX) begin
                    for (int k = 0; k < 3; k++) begin
                        pt[k] = P[i][k];
                        for (int q = i + 1; q < j; q++) pt[k] = fm(pt[k], P[q][k]);
                    end
                    bv = pt[0]; bm = 2'd0;
                    for (int k = 1; k < 3; k++) if (pt[k] > bv) begin bv = pt[k]; bm = 2'(k); end
                    c = fm(bv, bestc[i]);
                    if (!have || c > bc) begin
                        have = 1'b1; bc = c; from_b[j] = i; mode_b[j] = bm;
                    end
                end
            end
            bestc[j] = bc;
        end
    endtask

    task automatic insert(input int m);
        int exp_ext, sum;
        for (int k = 0; k < 3; k++) cur_p[k] = P[m][k];
        ext_cnt = 0; fresh_cnt = 0;
        @(negedge clk);
        seg_valid = 1'b1; seg_dur = 8'(D[m]);
        @(negedge clk);
        seg_valid = 1'b0;
        while (busy) @(negedge clk);
        exp_ext = 0;
        for (int i = 0; i < m; i++) begin
            sum = 0;
            for (int q = i; q <= m; q++) sum += D[q];
            if (sum <= TMAX) exp_ext++;
        end
        check(ext_cnt == exp_ext, "R3 window requests", ext_cnt, exp_ext);
        check(fresh_cnt == 1, "R2 fresh request", fresh_cnt, 1);
    endtask

    task automatic run_trace(input int n, input bit compare);
        int got, j, cyc;
        logic [1:0] seen [MAXS+1];
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        got = 0; cyc = 0;
        while (!trace_done && cyc < 100) begin
            if (trace_valid && got <= MAXS) begin seen[got] = trace_mode; got++; end
            @(negedge clk);
            cyc++;
        end
        check(trace_done == 1'b1, "R7 done pulse", int'(trace_done), 1);
        if (compare) begin
            expected_path(n);
            j = n;
            for (int e = 0; j > 0; e++) begin
                if (e < got)
                    check(seen[e] == mode_b[j], "R4/R6/R7 trace mode", int'(seen[e]), int'(mode_b[j]));
                else
                    check(1'b0, "R7 trace too short", got, e + 1);
                j = from_b[j];
                if (j == 0) check(got == e + 1, "R7 trace length", got, e + 1);
            end
            if (n == 0) check(got == 0, "R7 empty trace", got, 0);
        end
        @(negedge clk);
        check(overflow == 1'b0 && busy == 1'b0, "R8 restart state", int'(overflow), 0);
    endtask

    task automatic session(input int n);
        for (int m = 0; m < n; m++) insert(m);
        run_trace(n, 1'b1);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && sc_req == 0 && trace_valid == 0 && trace_done == 0 && overflow == 0,
              "R1 reset outputs", int'({busy, sc_req, trace_valid, trace_done, overflow}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: empty session
        run_trace(0, 1'b1);

        // R3 boundary: total exactly TMAX kept, one above dropped
        D[0] = 50; D[1] = 50;
        for (int k = 0; k < 3; k++) begin P[0][k] = 16'h8000 + 16'(k); P[1][k] = 16'hC000 - 16'(k); end
        session(2);
        D[0] = 50; D[1] = 51;
        session(2);

        // R4 ties: equal likelihoods everywhere, older source wins
        for (int m = 0; m < 5; m++) begin
            D[m] = 20;
            for (int k = 0; k < 3; k++) P[m][k] = 16'hFFFF;
        end
        session(5);

        // R5 single segment from the start boundary
        D[0] = 99; P[0][0] = 16'h1000; P[0][1] = 16'h2000; P[0][2] = 16'h3000;
        session(1);

        // sweep over pseudo-random sessions (R3, R4, R6)
        for (int s = 0; s < 40; s++) begin
            int n;
            rng = nxt(rng);
            n = 2 + int'(rng[3:0]) % 10;
            for (int m = 0; m < n; m++) begin
                rng = nxt(rng);
                D[m] = 5 + int'(rng[7:0]) % 56;
                for (int k = 0; k < 3; k++) begin
                    rng = nxt(rng);
                    P[m][k] = (rng[2:0] == 3'd0) ? 16'h8000 : {1'b1, rng[14:0]} >> rng[17:16];
                end
            end
            session(n);
        end

        // R9: 16 insertions fit, the 17th overflows
        for (int m = 0; m < 17; m++) begin
            D[m] = 1;
            for (int k = 0; k < 3; k++) P[m][k] = 16'hF000;
        end
        for (int m = 0; m < 16; m++) insert(m);
        check(overflow == 1'b0, "R9 no overflow at 16", int'(overflow), 0);
        insert(16);
        check(overflow == 1'b1, "R9 overflow at 17", int'(overflow), 1);
        run_trace(17, 1'b0);

        // R8: clean session after overflow
        D[0] = 30; D[1] = 30; D[2] = 30;
        for (int m = 0; m < 3; m++)
            for (int k = 0; k < 3; k++) P[m][k] = 16'h4000 + 16'(m * 16'h1111 + k * 16'h0700);
        session(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule